// File: doc/BRIEF.md
# Mesochronous Four-Entry Retiming Queue

This block carries a stream of words from a recovered sampling clock into the local receiving clock. The two clocks run at the same frequency. Their phase relation is unknown, and it may drift, skew or jitter. The block is a small cyclic queue. The writer stores one slot on every sampling-clock cycle, and the reader empties one slot on every receiving-clock cycle. Because the two rates match, the queue never fills and never drains, so it produces no occupancy flags.

Each slot holds a data word and the valid bit that came with it. After reset the writer waits for the first valid word. From that word onward it writes every cycle. A start flag is carried across to the read domain through a short synchronizer. The latency of that synchronizer leaves the read pointer about two slots behind the write pointer, which is half the queue. This margin covers up to half a cycle of phase error in either direction. Both pointers count in Gray code.

Top module: `meso_retimer`

## Requirements
- R1: While the read reset input is low, `rd_valid` is 0, and it drops to 0 as soon as that reset falls, without waiting for a clock edge.
- R2: Before the first sampling-clock edge that captures `wr_valid`=1, the queue does not start, and `wr_data` has no effect. `rd_valid` stays 0 for as long as this lasts.
- R3: The first valid word appears on `rd_data` with `rd_valid`=1 right after the third rising edge of `rd_clk` that comes strictly later than the `wr_clk` edge that captured it.
- R4: Once started, each following `rd_clk` rising edge presents the next stored word, in write order, with no word lost or repeated.
- R5: `rd_valid` on each output word equals the `wr_valid` captured with that word (1 = valid). Gaps in the input therefore reappear as gaps in the output, and `rd_valid` stays high across a run of valid inputs.
- R6: For any fixed phase offset of `rd_clk` relative to `wr_clk` within one period, the count of valid words out equals the count of valid words in.
- R7: After both resets are pulsed, the stream restarts cleanly. The first output word is the first valid word written after the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered sampling clock |
| wr_rst_n | input | 1 | Write-domain reset, active low, asynchronous assert |
| wr_data | input | DW | Word captured on every `wr_clk` rising edge |
| wr_valid | input | 1 | Qualifier captured with `wr_data` |
| rd_clk | input | 1 | Local receiving clock, same frequency as `wr_clk` |
| rd_rst_n | input | 1 | Read-domain reset, active low, asynchronous assert |
| rd_data | output | DW | Retimed word |
| rd_valid | output | 1 | Qualifier of `rd_data` |

## Verification
The interesting collision is a write into one slot and a read of a neighbouring slot at the same instant. The bench provokes it with a phase offset of zero, so that both clock edges land in the same time step. It then shifts `rd_clk` by 3 ns and 7 ns so that the read edge comes late in the write cycle, and shifts it again for a further case. At every one of these offsets, a timestamp-based queue model predicts the exact start edge and the word expected at each read edge. The bench compares the design against that model on every receiving-clock cycle, so a read that overtakes the write, or a slot that is overwritten before it is read, shows up as a wrong word.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
  // Number of synchronizer flops on the start flag; its latency sets the
  // read lag behind the write pointer.
  localparam int unsigned RTM_SYNC_STAGES = 2;
  localparam int unsigned RTM_DEPTH       = 4;
endpackage

// File: rtl/rtm_rst_sync.sv
module rtm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/rtm_gray_ctr.sv
module rtm_gray_ctr #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] gray_q
);
  logic [W-1:0] bin_cur;
  logic [W-1:0] bin_inc;
  logic [W-1:0] gray_d;

  function automatic logic [W-1:0] to_bin(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  always_comb begin
    bin_cur = to_bin(gray_q);
    bin_inc = bin_cur + W'(1);
    gray_d  = en ? (bin_inc ^ (bin_inc >> 1)) : gray_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gray_q <= '0;
    else        gray_q <= gray_d;
  end
endmodule

// File: rtl/rtm_wr_side.sv
module rtm_wr_side #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned SLOT_W = DW + 1
) (
  input  logic                     wclk,
  input  logic                     wrst_n,
  input  logic [DW-1:0]            wdata,
  input  logic                     wvalid,
  output logic                     started_q,
  output logic [PTR_W-1:0]         wptr_g,
  output logic [DEPTH*SLOT_W-1:0]  slots_flat
);
  logic            started_d;
  logic            wr_en;
  logic            slot_v_q [DEPTH];
  logic [DW-1:0]   slot_d_q [DEPTH];

  // Writing begins with the first valid word and then never pauses.
  always_comb begin
    wr_en     = started_q | wvalid;
    started_d = started_q | wvalid;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) started_q <= 1'b0;
    else         started_q <= started_d;
  end

  rtm_gray_ctr #(.W(PTR_W)) u_wptr (
    .clk    (wclk),
    .rst_n  (wrst_n),
    .en     (wr_en),
    .gray_q (wptr_g)
  );

  // Slots are indexed directly by the Gray value: any bijection will do.
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic sel;
    logic v_d;
    logic [DW-1:0] d_d;

    always_comb begin
      sel = wr_en && (wptr_g == PTR_W'(s));
      v_d = sel ? wvalid : slot_v_q[s];
      d_d = sel ? wdata  : slot_d_q[s];
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
      if (!wrst_n) slot_v_q[s] <= 1'b0;
      else         slot_v_q[s] <= v_d;
    end

    always_ff @(posedge wclk) begin
      slot_d_q[s] <= d_d;
    end

    assign slots_flat[s*SLOT_W +: SLOT_W] = {slot_v_q[s], slot_d_q[s]};
  end
endmodule

// File: rtl/rtm_rd_side.sv
module rtm_rd_side #(
  parameter int unsigned DW          = 16,
  parameter int unsigned DEPTH       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned SLOT_W = DW + 1
) (
  input  logic                     rclk,
  input  logic                     rrst_n,
  input  logic                     wr_started,
  input  logic [DEPTH*SLOT_W-1:0]  slots_flat,
  output logic                     rd_run,
  output logic [PTR_W-1:0]         rptr_g,
  output logic [DW-1:0]            rdata,
  output logic                     rvalid
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic [SLOT_W-1:0]      slot_view [DEPTH];
  logic [SLOT_W-1:0]      slot_sel;
  logic [DW-1:0]          rdata_d;
  logic                   rvalid_d;

  for (genvar s = 0; s < DEPTH; s++) begin : g_view
    assign slot_view[s] = slots_flat[s*SLOT_W +: SLOT_W];
  end

  // Start flag crossing; its latency is the read lag.
  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], wr_started};
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rd_run = sync_q[SYNC_STAGES-1];

  rtm_gray_ctr #(.W(PTR_W)) u_rptr (
    .clk    (rclk),
    .rst_n  (rrst_n),
    .en     (rd_run),
    .gray_q (rptr_g)
  );

  always_comb begin
    slot_sel = slot_view[rptr_g];
    rdata_d  = rd_run ? slot_sel[DW-1:0] : rdata;
    rvalid_d = rd_run & slot_sel[DW];
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rdata  <= rdata_d;
      rvalid <= rvalid_d;
    end
  end
endmodule

// File: rtl/meso_retimer.sv
module meso_retimer #(
  parameter int unsigned DW          = 16,
  parameter int unsigned DEPTH       = rtm_pkg::RTM_DEPTH,
  parameter int unsigned SYNC_STAGES = rtm_pkg::RTM_SYNC_STAGES
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_valid,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  localparam int unsigned PTR_W  = $clog2(DEPTH);
  localparam int unsigned SLOT_W = DW + 1;

  logic                    wrst_s_n;
  logic                    rrst_s_n;
  logic                    wr_started;
  logic                    rd_run;
  logic [PTR_W-1:0]        wptr_g;
  logic [PTR_W-1:0]        rptr_g;
  logic [DEPTH*SLOT_W-1:0] slots_flat;

  rtm_rst_sync #(.STAGES(2)) u_wrst (
    .clk    (wr_clk),
    .arst_n (wr_rst_n),
    .srst_n (wrst_s_n)
  );

  rtm_rst_sync #(.STAGES(2)) u_rrst (
    .clk    (rd_clk),
    .arst_n (rd_rst_n),
    .srst_n (rrst_s_n)
  );

  rtm_wr_side #(.DW(DW), .DEPTH(DEPTH)) u_wr (
    .wclk       (wr_clk),
    .wrst_n     (wrst_s_n),
    .wdata      (wr_data),
    .wvalid     (wr_valid),
    .started_q  (wr_started),
    .wptr_g     (wptr_g),
    .slots_flat (slots_flat)
  );

  rtm_rd_side #(.DW(DW), .DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_rd (
    .rclk       (rd_clk),
    .rrst_n     (rrst_s_n),
    .wr_started (wr_started),
    .slots_flat (slots_flat),
    .rd_run     (rd_run),
    .rptr_g     (rptr_g),
    .rdata      (rd_data),
    .rvalid     (rd_valid)
  );
endmodule

// File: rtl/rtm_chk.sv
module rtm_chk #(
  parameter int unsigned PTR_W = 2
) (
  input logic             wclk,
  input logic             rclk,
  input logic             wrst_s_n,
  input logic             rrst_s_n,
  input logic             wvalid,
  input logic             wr_started,
  input logic             rd_run,
  input logic [PTR_W-1:0] wptr_g,
  input logic [PTR_W-1:0] rptr_g,
  input logic             rvalid
);
  // R4
  wr_gray_step_chk: assert property (@(posedge wclk) disable iff (!wrst_s_n)
    (wptr_g != $past(wptr_g)) |-> ($countones(wptr_g ^ $past(wptr_g)) == 1));

  // R4
  rd_gray_step_chk: assert property (@(posedge rclk) disable iff (!rrst_s_n)
    (rptr_g != $past(rptr_g)) |-> ($countones(rptr_g ^ $past(rptr_g)) == 1));

  // R2
  wr_hold_chk: assert property (@(posedge wclk) disable iff (!wrst_s_n)
    (!wr_started && !wvalid) |=> $stable(wptr_g));

  // R2
  rd_hold_chk: assert property (@(posedge rclk) disable iff (!rrst_s_n)
    !rd_run |=> $stable(rptr_g));

  // R1
  rd_idle_chk: assert property (@(posedge rclk) disable iff (!rrst_s_n)
    !rd_run |=> !rvalid);

  // R4
  rd_sticky_chk: assert property (@(posedge rclk) disable iff (!rrst_s_n)
    rd_run |=> rd_run);
endmodule

bind meso_retimer rtm_chk #(.PTR_W(PTR_W)) u_chk (
  .wclk       (wr_clk),
  .rclk       (rd_clk),
  .wrst_s_n   (wrst_s_n),
  .rrst_s_n   (rrst_s_n),
  .wvalid     (wr_valid),
  .wr_started (wr_started),
  .rd_run     (rd_run),
  .wptr_g     (wptr_g),
  .rptr_g     (rptr_g),
  .rvalid     (rd_valid)
);

// File: tb/sim_meso_retimer.sv
`timescale 1ns/1ps
module sim_meso_retimer;
  localparam int PERIOD = 10;
  localparam int DW     = 16;

  logic          wr_clk, rd_clk, wr_rst_n, rd_rst_n, wr_valid, rd_valid;
  logic [DW-1:0] wr_data, rd_data;

  int vectors = 0;
  int fails   = 0;
  int shift_ns = 0;

  logic [DW:0] q [$];
  bit    wstarted = 0;
  realtime wstart_t = 0.0;
  int    redge = 0;
  bit    exp_act = 0, exp_v = 0, exp_first = 0;
  logic [DW-1:0] exp_d = '0;
  int    n_in = 0, n_out = 0;
  string first_tag = "R3";

  meso_retimer #(.DW(DW)) u0 (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_data(wr_data), .wr_valid(wr_valid),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  initial begin
    wr_clk = 0;
    forever #(PERIOD/2) wr_clk = ~wr_clk;
  end

  initial begin
    rd_clk = 0;
    forever begin
      if (shift_ns > 0) begin
        #(shift_ns);
        shift_ns = 0;
      end
      rd_clk = 1;
      #(PERIOD/2);
      rd_clk = 0;
      #(PERIOD/2);
    end
  end

  // Write-side model: records every captured entry once writing has begun.
  always @(posedge wr_clk) begin
    if (wr_rst_n && (wstarted || wr_valid)) begin
      if (!wstarted) begin
        wstarted = 1;
        wstart_t = $realtime;
      end
      q.push_back({wr_valid, wr_data});
      if (wr_valid) n_in++;
    end
  end

  // Read-side model: third read edge strictly after the first capture pops.
  always @(posedge rd_clk) begin
    if (rd_rst_n && wstarted && ($realtime > wstart_t)) begin
      redge++;
      if (redge >= 3) begin
        exp_first = (redge == 3);
        if (q.size() == 0) begin
          fails++; vectors++;
          $display("FAIL R4 model queue empty: actual pop request, expected stored entry");
          exp_act = 0;
        end else begin
          {exp_v, exp_d} = q.pop_front();
          exp_act = 1;
        end
      end
    end
  end

  always @(negedge rd_clk) begin
    if (rd_rst_n) begin
      vectors++;
      if (!exp_act) begin
        if (rd_valid !== 1'b0) begin
          fails++;
          $display("FAIL R2 idle: rd_valid actual %b expected 0", rd_valid);
        end
      end else begin
        if (rd_valid !== exp_v) begin
          fails++;
          $display("FAIL %s rd_valid: actual %b expected %b", exp_first ? first_tag : "R5", rd_valid, exp_v);
        end else if (exp_v && rd_data !== exp_d) begin
          fails++;
          $display("FAIL %s rd_data: actual %h expected %h", exp_first ? first_tag : "R4", rd_data, exp_d);
        end
      end
      if (rd_valid === 1'b1) n_out++;
    end
  end

  task automatic do_reset(input int shift);
    @(negedge wr_clk);
    #1;
    wr_rst_n = 0;
    rd_rst_n = 0;
    #1;
    vectors++;
    if (rd_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 async reset: rd_valid actual %b expected 0", rd_valid);
    end
    q.delete();
    wstarted = 0; redge = 0; exp_act = 0; exp_first = 0;
    n_in = 0; n_out = 0;
    shift_ns = shift;
    repeat (5) @(negedge wr_clk);
    wr_rst_n = 1;
    rd_rst_n = 1;
    repeat (6) @(negedge wr_clk);
  endtask

  task automatic drive(input int n, input int gap_mod, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_valid = (gap_mod == 0) ? 1'b1 : ((i % gap_mod) != 2);
      wr_data  = DW'(base + i);
    end
    @(negedge wr_clk);
    wr_valid = 0;
    wr_data  = 16'hdead;
  endtask

  task automatic count_check(input int offs);
    repeat (12) @(negedge wr_clk);
    vectors++;
    if (n_out != n_in) begin
      fails++;
      $display("FAIL R6 offset %0d: valid out actual %0d expected %0d", offs, n_out, n_in);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    wr_rst_n = 0; rd_rst_n = 0; wr_valid = 0; wr_data = '0;
    // Phase offset 0: coincident edges; idle garbage first (R2), then R3/R4.
    do_reset(0);
    for (int i = 0; i < 20; i++) begin
      @(negedge wr_clk);
      wr_data = DW'(16'h5a00 + i);
    end
    drive(40, 0, 16'h0100);
    count_check(0);

    // Offset 3 ns with gaps (R5).
    do_reset(3);
    drive(40, 5, 16'h0200);
    count_check(3);

    // Offset 7 ns, then reset mid-stream (R1).
    do_reset(4);
    drive(30, 0, 16'h0300);
    count_check(7);
    fork
      drive(30, 7, 16'h0400);
      begin
        repeat (20) @(negedge wr_clk);
        #2;
        rd_rst_n = 0;
        wr_rst_n = 0;
        #1;
        vectors++;
        if (rd_valid !== 1'b0) begin
          fails++;
          $display("FAIL R1 mid-stream reset: rd_valid actual %b expected 0", rd_valid);
        end
      end
    join

    // Restart after reset at offset 9 ns (R7).
    first_tag = "R7";
    do_reset(2);
    drive(25, 4, 16'h0500);
    count_check(9);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule